// File: doc/BRIEF.md
# Board Bring-Up and Loadware Download Sequencer

This block sits on the host side of a multiport serial interface board and brings the board from reset to running firmware without software stepping through each access. After a start pulse it resets the board twice, with a timed pause between the two resets. It then drains the 16-byte power-on message that the board's boot firmware places in the inbound FIFO and checks the two identification bytes. It keeps the family and FIFO-size fields, streams the loadware image from a byte source into the outbound FIFO in fixed-size blocks, and finally reads the one-byte verdict the board returns.

All waits are bounded by one millisecond timer whose tick is derived from a clock prescaler, so a simulation can shrink every delay by changing parameters. The run ends in a terminal state with `done` high and a 3-bit result code. A new start pulse repeats the whole sequence.

Top module: `board_boot_seq`

## Requirements
- R1: A start pulse produces a one-cycle `board_rst` pulse, then a second one-cycle pulse exactly RESET_GAP_MS*CLK_PER_MS+2 clock cycles after the first.
- R2: After the second reset, `rd_strobe` is raised only in cycles where `st_in_empty` is low, and each strobe consumes the byte on `rd_data` in that cycle. Exactly 16 message bytes are read before any write.
- R3: Message byte 0 must be 0x96 and byte 1 must be 0x35. On the first mismatch no further byte is read, and the run ends with code 2 (bad identification).
- R4: If the message is not fully read within MSG_WAIT_MS of the second reset, the run ends with code 1.
- R5: `msg_family` holds bits 7:6 of message byte 5 (0 = fixed-size board, 1 = expandable board). `msg_fifo_log2` holds message byte 13, the base-2 logarithm of the FIFO size.
- R6: Loadware bytes are written in source order, with `wr_strobe` only while `st_out_full` is low. The first byte of the first block must be 0x3C; otherwise it is not written and the run ends with code 3.
- R7: The second byte of the first block gives the number of blocks that follow. Exactly (that number + 1) * BLOCK_BYTES bytes are written.
- R8: The first block may take FIRST_BLK_MS and each later block NEXT_BLK_MS, measured from the block's start. Overrunning the allowance ends the run with code 4.
- R9: The verdict byte 0xC3 ends the run with code 0, 0x5A ends it with code 6 (checksum failure), and any other value ends it with code 7.
- R10: If no verdict byte arrives within VERDICT_MS of the last loadware byte, the run ends with code 5.
- R11: Out of reset and after `done`, no strobe of any kind is raised until the next start pulse. `done` is low and the code is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up run (idle or finished) |
| st_in_empty | input | 1 | Inbound FIFO empty flag |
| st_out_full | input | 1 | Outbound FIFO full flag |
| rd_data | input | 8 | Data port read value, valid with rd_strobe |
| src_valid | input | 1 | Loadware source has a byte |
| src_data | input | 8 | Loadware byte |
| src_ready | output | 1 | Sequencer can take a loadware byte |
| board_rst | output | 1 | Write strobe to the board reset address |
| rd_strobe | output | 1 | Data port read strobe |
| wr_strobe | output | 1 | Data port write strobe |
| wr_data | output | 8 | Data port write value |
| done | output | 1 | Run finished |
| err_code | output | 3 | Result: 0 ok, 1 message timeout, 2 bad id, 3 bad header, 4 block timeout, 5 verdict timeout, 6 checksum, 7 unknown verdict |
| msg_family | output | 2 | Family field from the power-on message |
| msg_fifo_log2 | output | 8 | FIFO size exponent from the power-on message |

## Verification
A clean two-block image with an accepted verdict is contrasted with runs that each break one step. These runs corrupt either identification byte (telling the first-byte and second-byte stops apart by the read count), withhold the message, corrupt the load header, or answer with the checksum code, an unknown code or nothing. The same 200-cycle outbound-full stall is placed once in a first block and once in a later block. It must pass in the first and time out in the second, which separates the two allowances. Two messages with different family and size bytes confirm the captured fields.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

    localparam int MSG_BYTES    = 16;
    localparam int IDX_FAMILY   = 5;
    localparam int IDX_FIFO     = 13;

    localparam logic [7:0] ID_BYTE_A    = 8'h96;
    localparam logic [7:0] ID_BYTE_B    = 8'h35;
    localparam logic [7:0] LOAD_MAGIC   = 8'h3C;
    localparam logic [7:0] VERDICT_GOOD = 8'hC3;
    localparam logic [7:0] VERDICT_CRC  = 8'h5A;

    typedef enum logic [2:0] {
        ERR_NONE            = 3'd0,
        ERR_MSG_TIMEOUT     = 3'd1,
        ERR_BAD_ID          = 3'd2,
        ERR_BAD_HEADER      = 3'd3,
        ERR_BLOCK_TIMEOUT   = 3'd4,
        ERR_VERDICT_TIMEOUT = 3'd5,
        ERR_CRC             = 3'd6,
        ERR_UNKNOWN_VERDICT = 3'd7
    } boot_err_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RST1, ST_GAP, ST_RST2, ST_MSG, ST_LOAD, ST_VERDICT, ST_END
    } boot_state_e;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic boot_err_e classify_verdict(logic [7:0] v);
        if (v == VERDICT_GOOD) return ERR_NONE;
        if (v == VERDICT_CRC)  return ERR_CRC;
        return ERR_UNKNOWN_VERDICT;
    endfunction

endpackage

// File: rtl/boot_ms_timer.sv
module boot_ms_timer #(
    parameter int CLK_PER_MS = 50000,
    parameter int MS_W       = 11
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [MS_W-1:0] limit,
    output logic            expired
);
    localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;

    assign expired = (ms_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (!expired) begin
            if (pre_q == PRE_W'(CLK_PER_MS - 1)) begin
                pre_q <= '0;
                ms_q  <= ms_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/boot_msg_capture.sv
module boot_msg_capture
    import bootseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       take,
    input  logic [7:0] data,
    output logic       bad_id,
    output logic       last,
    output logic [1:0] family,
    output logic [7:0] fifo_log2
);
    localparam int IDX_W = $clog2(MSG_BYTES);

    logic [IDX_W-1:0] idx_q;

    always_comb begin
        bad_id = 1'b0;
        if (take && idx_q == IDX_W'(0) && data != ID_BYTE_A) bad_id = 1'b1;
        if (take && idx_q == IDX_W'(1) && data != ID_BYTE_B) bad_id = 1'b1;
    end

    assign last = take && (idx_q == IDX_W'(MSG_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            family    <= '0;
            fifo_log2 <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(IDX_FAMILY)) family    <= data[7:6];
            if (idx_q == IDX_W'(IDX_FIFO))   fifo_log2 <= data;
        end
    end
endmodule

// File: rtl/board_boot_seq.sv
module board_boot_seq
    import bootseq_pkg::*;
#(
    parameter int CLK_PER_MS   = 50000,
    parameter int RESET_GAP_MS = 50,
    parameter int MSG_WAIT_MS  = 2000,
    parameter int FIRST_BLK_MS = 1000,
    parameter int NEXT_BLK_MS  = 100,
    parameter int VERDICT_MS   = 100,
    parameter int BLOCK_BYTES  = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       st_in_empty,
    input  logic       st_out_full,
    input  logic [7:0] rd_data,
    input  logic       src_valid,
    input  logic [7:0] src_data,
    output logic       src_ready,
    output logic       board_rst,
    output logic       rd_strobe,
    output logic       wr_strobe,
    output logic [7:0] wr_data,
    output logic       done,
    output logic [2:0] err_code,
    output logic [1:0] msg_family,
    output logic [7:0] msg_fifo_log2
);
    localparam int MAX_MS = imax(imax(imax(RESET_GAP_MS, MSG_WAIT_MS),
                                      imax(FIRST_BLK_MS, NEXT_BLK_MS)), VERDICT_MS);
    localparam int MS_W   = $clog2(MAX_MS + 1);
    localparam int BI_W   = $clog2(BLOCK_BYTES);

    boot_state_e     state_q;
    boot_err_e       err_q;
    logic [BI_W-1:0] byte_idx_q;
    logic [7:0]      blocks_left_q;
    logic            first_blk_q;

    logic            rd_fire, src_fire, hdr_bad, blk_end;
    logic            msg_take, cap_bad, cap_last;
    logic            tmr_clr, tmr_expired;
    logic [MS_W-1:0] tmr_limit;

    assign rd_fire   = (state_q == ST_MSG || state_q == ST_VERDICT) && !st_in_empty;
    assign msg_take  = rd_fire && (state_q == ST_MSG);
    assign src_ready = (state_q == ST_LOAD) && !st_out_full;
    assign src_fire  = src_valid && src_ready;
    assign hdr_bad   = src_fire && first_blk_q && byte_idx_q == '0 && src_data != LOAD_MAGIC;
    assign blk_end   = src_fire && !hdr_bad && byte_idx_q == BI_W'(BLOCK_BYTES - 1);

    assign board_rst = (state_q == ST_RST1) || (state_q == ST_RST2);
    assign rd_strobe = rd_fire;
    assign wr_strobe = src_fire && !hdr_bad;
    assign wr_data   = src_data;
    assign done      = (state_q == ST_END);
    assign err_code  = err_q;

    assign tmr_clr = board_rst || cap_last || blk_end;

    always_comb begin
        unique case (state_q)
            ST_GAP:     tmr_limit = MS_W'(RESET_GAP_MS);
            ST_MSG:     tmr_limit = MS_W'(MSG_WAIT_MS);
            ST_LOAD:    tmr_limit = first_blk_q ? MS_W'(FIRST_BLK_MS) : MS_W'(NEXT_BLK_MS);
            ST_VERDICT: tmr_limit = MS_W'(VERDICT_MS);
            default:    tmr_limit = '1;
        endcase
    end

    boot_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) u_timer (
        .clk(clk), .rst(rst), .clr(tmr_clr), .limit(tmr_limit), .expired(tmr_expired)
    );

    boot_msg_capture u_capture (
        .clk(clk), .rst(rst), .clr(state_q == ST_RST2), .take(msg_take), .data(rd_data),
        .bad_id(cap_bad), .last(cap_last), .family(msg_family), .fifo_log2(msg_fifo_log2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            err_q         <= ERR_NONE;
            byte_idx_q    <= '0;
            blocks_left_q <= '0;
            first_blk_q   <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_END: if (start) begin
                    state_q <= ST_RST1;
                    err_q   <= ERR_NONE;
                end
                ST_RST1: state_q <= ST_GAP;
                ST_GAP:  if (tmr_expired) state_q <= ST_RST2;
                ST_RST2: state_q <= ST_MSG;
                ST_MSG: begin
                    if (cap_bad) begin
                        state_q <= ST_END;
                        err_q   <= ERR_BAD_ID;
                    end else if (cap_last) begin
                        state_q     <= ST_LOAD;
                        byte_idx_q  <= '0;
                        first_blk_q <= 1'b1;
                    end else if (tmr_expired) begin
                        state_q <= ST_END;
                        err_q   <= ERR_MSG_TIMEOUT;
                    end
                end
                ST_LOAD: begin
                    if (hdr_bad) begin
                        state_q <= ST_END;
                        err_q   <= ERR_BAD_HEADER;
                    end else if (blk_end) begin
                        byte_idx_q  <= '0;
                        first_blk_q <= 1'b0;
                        if (blocks_left_q == 8'd0) state_q <= ST_VERDICT;
                        else blocks_left_q <= blocks_left_q - 8'd1;
                    end else if (tmr_expired) begin
                        state_q <= ST_END;
                        err_q   <= ERR_BLOCK_TIMEOUT;
                    end else if (src_fire) begin
                        byte_idx_q <= byte_idx_q + 1'b1;
                        if (first_blk_q && byte_idx_q == BI_W'(1)) blocks_left_q <= src_data;
                    end
                end
                ST_VERDICT: begin
                    if (rd_fire) begin
                        state_q <= ST_END;
                        err_q   <= classify_verdict(rd_data);
                    end else if (tmr_expired) begin
                        state_q <= ST_END;
                        err_q   <= ERR_VERDICT_TIMEOUT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/boot_seq_checker.sv
module boot_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       st_in_empty,
    input logic       st_out_full,
    input logic [7:0] rd_data,
    input logic       board_rst,
    input logic       rd_strobe,
    input logic       wr_strobe,
    input logic       done,
    input logic [2:0] err_code
);
    logic [4:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (rst || board_rst) rd_cnt <= '0;
        else if (rd_strobe && rd_cnt != 5'd31) rd_cnt <= rd_cnt + 5'd1;
    end

    assert_reset_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        board_rst |=> !board_rst);

    assert_read_when_data_R2: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> !st_in_empty);

    assert_first_id_stop_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rd_cnt == 5'd0 && rd_data != 8'h96) |=> (done && err_code == 3'd2));

    assert_second_id_stop_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rd_cnt == 5'd1 && rd_data != 8'h35) |=> (done && err_code == 3'd2));

    assert_write_when_room_R6: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> !st_out_full);

    assert_verdict_good_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rd_cnt == 5'd16 && rd_data == 8'hC3) |=> (done && err_code == 3'd0));

    assert_verdict_crc_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rd_cnt == 5'd16 && rd_data == 8'h5A) |=> (done && err_code == 3'd6));

    assert_quiet_when_done_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !(rd_strobe || wr_strobe || board_rst));
endmodule

bind board_boot_seq boot_seq_checker u_chk (
    .clk(clk), .rst(rst), .st_in_empty(st_in_empty), .st_out_full(st_out_full),
    .rd_data(rd_data), .board_rst(board_rst), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .done(done), .err_code(err_code)
);

// File: tb/board_boot_seq_test.sv
module board_boot_seq_test;
    localparam int P      = 8;
    localparam int GAP    = 5;
    localparam int BLK    = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic st_in_empty = 1'b1, st_out_full = 1'b0, src_valid = 1'b0;
    logic [7:0] rd_data = '0, src_data = '0;
    logic src_ready, board_rst, rd_strobe, wr_strobe, done;
    logic [7:0] wr_data, msg_fifo_log2;
    logic [2:0] err_code;
    logic [1:0] msg_family;

    board_boot_seq #(.CLK_PER_MS(P), .RESET_GAP_MS(GAP), .MSG_WAIT_MS(20),
        .FIRST_BLK_MS(100), .NEXT_BLK_MS(80), .VERDICT_MS(10), .BLOCK_BYTES(BLK)) uut (
        .clk(clk), .rst(rst), .start(start), .st_in_empty(st_in_empty),
        .st_out_full(st_out_full), .rd_data(rd_data), .src_valid(src_valid),
        .src_data(src_data), .src_ready(src_ready), .board_rst(board_rst),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .wr_data(wr_data), .done(done),
        .err_code(err_code), .msg_family(msg_family), .msg_fifo_log2(msg_fifo_log2));

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    logic [7:0] rx_q[$], src_q[$], exp_q[$], msg_q[$];
    bit   have_msg, have_verdict, v_pushed, full_hold;
    logic [7:0] verdict;
    int   rst_seen, rst1_cyc, rst2_cyc, rd_count, wr_count, want_writes, late;
    bit   rd_take, src_take, rst_take;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // board and loadware source model plus write monitor (scoreboard)
    initial forever begin
        @(negedge clk);
        if (rd_take && rx_q.size() > 0) void'(rx_q.pop_front());
        if (src_take) void'(src_q.pop_front());
        if (rst_take) begin
            rx_q.delete();
            rst_seen++;
            if (rst_seen == 2 && have_msg) foreach (msg_q[i]) rx_q.push_back(msg_q[i]);
        end
        if (have_verdict && !v_pushed && want_writes > 0 && wr_count == want_writes) begin
            rx_q.push_back(verdict);
            v_pushed = 1'b1;
        end
        st_in_empty = (rx_q.size() == 0);
        rd_data     = (rx_q.size() > 0) ? rx_q[0] : 8'h00;
        src_valid   = (src_q.size() > 0);
        src_data    = (src_q.size() > 0) ? src_q[0] : 8'h00;
        st_out_full = full_hold;
        #1;
        rd_take  = rd_strobe;
        src_take = src_valid && src_ready;
        rst_take = board_rst;
        if (rd_strobe) rd_count++;
        if (board_rst) begin
            if (rst_seen == 0) rst1_cyc = cyc; else rst2_cyc = cyc;
        end
        if (done && (rd_strobe || wr_strobe || board_rst)) late++;
        if (wr_strobe) begin
            wr_count++;
            if (exp_q.size() == 0) check(0, "R6", "unexpected write", wr_data, -1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(wr_data == e, "R6", "write byte", wr_data, e);
            end
        end
    end

    // driver: builds message, image and expected write stream
    task automatic prep(logic [7:0] id_a, logic [7:0] id_b, logic [7:0] fam,
                        logic [7:0] fifo, bit msg_on, logic [7:0] hdr, int follow,
                        bit v_on, logic [7:0] v);
        rx_q.delete(); src_q.delete(); exp_q.delete(); msg_q.delete();
        for (int i = 0; i < 16; i++) msg_q.push_back(8'(i * 3 + 1));
        msg_q[0] = id_a; msg_q[1] = id_b; msg_q[5] = fam; msg_q[13] = fifo;
        have_msg = msg_on; have_verdict = v_on; verdict = v; v_pushed = 1'b0;
        rst_seen = 0; rd_count = 0; wr_count = 0; late = 0;
        for (int b = 0; b <= follow; b++)
            for (int i = 0; i < BLK; i++) begin
                logic [7:0] x;
                x = 8'(b * 7 + i * 13);
                if (b == 0 && i == 0) x = hdr;
                if (b == 0 && i == 1) x = 8'(follow);
                src_q.push_back(x);
                if (hdr == 8'h3C) exp_q.push_back(x);
            end
        want_writes = (hdr == 8'h3C) ? (follow + 1) * BLK : 0;
    endtask

    task automatic run(int stall_at);
        @(posedge clk); #2 start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        if (stall_at >= 0) begin
            wait (wr_count >= stall_at);
            @(posedge clk); #2 full_hold = 1'b1;
            repeat (200) @(posedge clk);
            #2 full_hold = 1'b0;
        end
        for (int n = 0; n < 6000 && !done; n++) @(negedge clk);
        #2;
        check(done, "R11", "run finished", done, 1);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired: actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk); #2;
        check(!done && !board_rst && !rd_strobe && !wr_strobe, "R11", "idle quiet", done, 0);
        check(err_code == 3'd0, "R11", "reset code", err_code, 0);

        // clean two-block image, expandable family
        prep(8'h96, 8'h35, 8'h41, 8'd9, 1, 8'h3C, 1, 1, 8'hC3);
        run(-1);
        check(rst2_cyc - rst1_cyc == GAP * P + 2, "R1", "reset spacing", rst2_cyc - rst1_cyc, GAP * P + 2);
        check(rd_count == 17, "R2", "reads incl verdict", rd_count, 17);
        check(msg_family == 2'd1, "R5", "family", msg_family, 1);
        check(msg_fifo_log2 == 8'd9, "R5", "fifo size", msg_fifo_log2, 9);
        check(wr_count == 2 * BLK, "R7", "bytes written", wr_count, 2 * BLK);
        check(exp_q.size() == 0, "R6", "stream drained", exp_q.size(), 0);
        check(err_code == 3'd0, "R9", "good verdict", err_code, 0);
        repeat (20) @(negedge clk);
        check(late == 0, "R11", "strobes after done", late, 0);

        prep(8'h95, 8'h35, 8'h41, 8'd9, 1, 8'h3C, 0, 1, 8'hC3);
        run(-1);
        check(err_code == 3'd2, "R3", "bad first id code", err_code, 2);
        check(rd_count == 1, "R3", "reads after first id", rd_count, 1);

        prep(8'h96, 8'h36, 8'h41, 8'd9, 1, 8'h3C, 0, 1, 8'hC3);
        run(-1);
        check(err_code == 3'd2, "R3", "bad second id code", err_code, 2);
        check(rd_count == 2, "R3", "reads after second id", rd_count, 2);

        prep(8'h96, 8'h35, 8'h41, 8'd9, 0, 8'h3C, 0, 1, 8'hC3);
        run(-1);
        check(err_code == 3'd1, "R4", "message timeout", err_code, 1);

        prep(8'h96, 8'h35, 8'h41, 8'd9, 1, 8'h11, 0, 1, 8'hC3);
        run(-1);
        check(err_code == 3'd3, "R6", "bad header code", err_code, 3);
        check(wr_count == 0, "R6", "no write on bad header", wr_count, 0);

        // stalled first block still fits, checksum verdict, fixed family
        prep(8'h96, 8'h35, 8'h02, 8'd10, 1, 8'h3C, 0, 1, 8'h5A);
        run(300);
        check(err_code == 3'd6, "R8", "first block allowance then crc (R9)", err_code, 6);
        check(msg_family == 2'd0, "R5", "fixed family", msg_family, 0);
        check(msg_fifo_log2 == 8'd10, "R5", "fifo size 2", msg_fifo_log2, 10);

        // same stall in a later block overruns
        prep(8'h96, 8'h35, 8'h41, 8'd9, 1, 8'h3C, 1, 1, 8'hC3);
        run(BLK + 300);
        check(err_code == 3'd4, "R8", "later block timeout", err_code, 4);

        prep(8'h96, 8'h35, 8'h41, 8'd9, 1, 8'h3C, 0, 1, 8'h77);
        run(-1);
        check(err_code == 3'd7, "R9", "unknown verdict", err_code, 7);

        prep(8'h96, 8'h35, 8'h41, 8'd9, 1, 8'h3C, 0, 0, 8'h00);
        run(-1);
        check(err_code == 3'd5, "R10", "verdict timeout", err_code, 5);
        check(wr_count == BLK, "R7", "single block written", wr_count, BLK);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule